// File: doc/BRIEF.md
# Sensor Node Power-Mode Sequencer

This controller steps a wireless sensor node through its duty cycle and drives a separate power state for each subsystem. The node has a processor, an analog front end, a converter, an anti-alias prefilter, a receiver, a transmitter and a frequency synthesizer. The cycle has four phases in a fixed order. First the node collects a fixed-size burst of converter samples paced by a sample-rate tick. Then it computes on the burst locally. Then it transmits the result. Then it sleeps with everything powered down until a wake timer expires or an external wake event arrives.

Each subsystem gets its own power level in each phase, so the controller does not gate the whole node with a single enable. During collection the processor is idle and wakes for one cycle after each sample tick. During computation it is fully active, and the converter, prefilter and analog supply drop to their low states. Before transmission the synthesizer is switched on for a fixed warm-up interval, and the transmitter is enabled only after that interval. The burst size, sleep length and warm-up length are parameters.

Top module: `node_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the controller is in sleep and every output is at its lowest-power encoding: `cpu_pwr`=2'b00 and all single-bit outputs are 0. This holds whatever the other inputs do.
- R2: With `wake_evt` low, sleep lasts exactly SLEEP_CYCLES clock cycles. Sleep is counted from reset release or from the transmit-to-sleep edge. The controller then enters collection, where `afe_on`=1, `adc_on`=1 and `filt_on`=1.
- R3: A high `wake_evt` sampled in sleep moves the controller into collection at that clock edge.
- R4: In collection, `cpu_pwr` is 2'b01 (idle), except in the cycle after a sampled `sample_tick`, when it is 2'b10 (active). `compute_done` and `tx_done` are ignored in collection. A `sample_tick` outside collection neither counts nor wakes the processor.
- R5: The NUM_SAMPLES-th tick of a collection moves the controller into compute at that edge. In compute, `cpu_pwr`=2'b10 and `afe_on`, `adc_on` and `filt_on` are 0. The sample count restarts at zero in every new collection.
- R6: Compute is held until `compute_done`. `tx_done` and `sample_tick` are ignored there.
- R7: After `compute_done`, `synth_on`=1 with `tx_on`=0 for exactly WARMUP_CYCLES cycles. Then `tx_on`=1 with `synth_on`=1. The processor stays active in both.
- R8: Transmit is held until `tx_done`. `tx_done` then returns the controller to sleep with all outputs at their R1 values.
- R9: `rx_on` is 0 in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_tick | input | 1 | One-cycle pulse at the sample rate |
| compute_done | input | 1 | Processor has finished the compute phase |
| tx_done | input | 1 | Radio has finished sending |
| wake_evt | input | 1 | External event that ends sleep early |
| cpu_pwr | output | 2 | Processor state: 00 sleep, 01 idle, 10 active |
| afe_on | output | 1 | Analog front-end supply on |
| adc_on | output | 1 | Converter active (0 = software shutdown) |
| filt_on | output | 1 | Prefilter active (0 = standby) |
| rx_on | output | 1 | Receiver on |
| tx_on | output | 1 | Transmitter on |
| synth_on | output | 1 | Synthesizer active (0 = standby) |

## Verification
Full duty cycles are run with a small burst size, and each cycle pairs a different way of leaving sleep with a different tick spacing. Some cycles wait for the timer, others give a wake event right away or part-way through sleep. This separates a timer that is off by one from a wake path that is ignored. Back-to-back ticks show whether the processor's active cycle follows every tick, and spaced ticks show whether it drops back to idle between them. Counting every full burst after a previous one shows whether the sample counter really restarts. Handshakes and ticks arriving in the wrong phase show that phases are not skipped.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    PH_SLEEP   = 3'd0,
    PH_COLLECT = 3'd1,
    PH_COMPUTE = 3'd2,
    PH_WARMUP  = 3'd3,
    PH_XMIT    = 3'd4
  } phase_e;

  localparam logic [1:0] CPU_SLEEP  = 2'b00;
  localparam logic [1:0] CPU_IDLE   = 2'b01;
  localparam logic [1:0] CPU_ACTIVE = 2'b10;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = clr || (cnt != CNT_MAX);
    cnt_nxt = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R2 / R7: phase timer advances by one per cycle inside a phase
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pwrseq_sample_ctr.sv
module pwrseq_sample_ctr #(
  parameter int N = 1024,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_en,
  output logic last
);
  localparam logic [W-1:0] LAST_IDX = W'(N - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    last    = tick_en && (cnt == LAST_IDX);
    cnt_en  = clr || tick_en;
    if (clr || last) cnt_nxt = '0;
    else             cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R5: count never reaches the burst size and restarts outside collection
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX);
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wake_evt,
  input  logic   sleep_expire,
  input  logic   last_sample,
  input  logic   compute_done,
  input  logic   warm_expire,
  input  logic   tx_done,
  output phase_e state,
  output phase_e state_nxt
);
  always_comb begin
    state_nxt = state;
    case (state)
      PH_SLEEP:   if (wake_evt || sleep_expire) state_nxt = PH_COLLECT;
      PH_COLLECT: if (last_sample)              state_nxt = PH_COMPUTE;
      PH_COMPUTE: if (compute_done)             state_nxt = PH_WARMUP;
      PH_WARMUP:  if (warm_expire)              state_nxt = PH_XMIT;
      PH_XMIT:    if (tx_done)                  state_nxt = PH_SLEEP;
      default:                                  state_nxt = PH_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_SLEEP;
    else        state <= state_nxt;
  end

  p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_SLEEP && wake_evt) |=> state == PH_COLLECT);
  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_COLLECT && last_sample) |=> state == PH_COMPUTE);
  p_compute_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_COMPUTE && !compute_done) |=> state == PH_COMPUTE);
  p_xmit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_XMIT && !tx_done) |=> state == PH_XMIT);
endmodule

// File: rtl/pwrseq_decode.sv
module pwrseq_decode
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     state,
  input  logic       tick_collect,
  output logic [1:0] cpu_pwr,
  output logic       afe_on,
  output logic       adc_on,
  output logic       filt_on,
  output logic       rx_on,
  output logic       tx_on,
  output logic       synth_on
);
  logic sample_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_wake <= 1'b0;
    else        sample_wake <= tick_collect;
  end

  always_comb begin
    cpu_pwr  = CPU_SLEEP;
    afe_on   = 1'b0;
    adc_on   = 1'b0;
    filt_on  = 1'b0;
    rx_on    = 1'b0;
    tx_on    = 1'b0;
    synth_on = 1'b0;
    case (state)
      PH_COLLECT: begin
        cpu_pwr = sample_wake ? CPU_ACTIVE : CPU_IDLE;
        afe_on  = 1'b1;
        adc_on  = 1'b1;
        filt_on = 1'b1;
      end
      PH_COMPUTE: cpu_pwr = CPU_ACTIVE;
      PH_WARMUP: begin
        cpu_pwr  = CPU_ACTIVE;
        synth_on = 1'b1;
      end
      PH_XMIT: begin
        cpu_pwr  = CPU_ACTIVE;
        synth_on = 1'b1;
        tx_on    = 1'b1;
      end
      default: ;
    endcase
  end

  // R4: a tick taken in collection wakes the processor in the following cycle
  p_tick_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_collect && state == PH_COLLECT) |=> cpu_pwr == CPU_ACTIVE);
endmodule

// File: rtl/node_pwr_seq.sv
module node_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int NUM_SAMPLES   = 1024,
  parameter int SLEEP_CYCLES  = 100000,
  parameter int WARMUP_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       compute_done,
  input  logic       tx_done,
  input  logic       wake_evt,
  output logic [1:0] cpu_pwr,
  output logic       afe_on,
  output logic       adc_on,
  output logic       filt_on,
  output logic       rx_on,
  output logic       tx_on,
  output logic       synth_on
);
  localparam int TMAX  = (SLEEP_CYCLES > WARMUP_CYCLES) ? SLEEP_CYCLES : WARMUP_CYCLES;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYCLES - 1);
  localparam logic [CNT_W-1:0] WARM_LAST  = CNT_W'(WARMUP_CYCLES - 1);

  phase_e           state;
  phase_e           state_nxt;
  logic [CNT_W-1:0] ph_cnt;
  logic             ph_clr;
  logic             sleep_expire;
  logic             warm_expire;
  logic             collecting;
  logic             tick_collect;
  logic             last_sample;

  always_comb begin
    ph_clr       = (state_nxt != state);
    sleep_expire = (ph_cnt == SLEEP_LAST);
    warm_expire  = (ph_cnt == WARM_LAST);
    collecting   = (state == PH_COLLECT);
    tick_collect = collecting && sample_tick;
  end

  pwrseq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ph_clr),
    .cnt   (ph_cnt)
  );

  pwrseq_sample_ctr #(.N(NUM_SAMPLES)) u_samples (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!collecting),
    .tick_en (tick_collect),
    .last    (last_sample)
  );

  pwrseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_evt     (wake_evt),
    .sleep_expire (sleep_expire),
    .last_sample  (last_sample),
    .compute_done (compute_done),
    .warm_expire  (warm_expire),
    .tx_done      (tx_done),
    .state        (state),
    .state_nxt    (state_nxt)
  );

  pwrseq_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .tick_collect (tick_collect),
    .cpu_pwr      (cpu_pwr),
    .afe_on       (afe_on),
    .adc_on       (adc_on),
    .filt_on      (filt_on),
    .rx_on        (rx_on),
    .tx_on        (tx_on),
    .synth_on     (synth_on)
  );

  // R7: transmitter is never on without the synthesizer
  p_tx_synth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_on |-> synth_on);
  // R7: transmitter turns on only after the synthesizer was already running
  p_tx_after_warm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> $past(synth_on));
  // R8: transmit end leads straight to full power-down
  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_XMIT && tx_done) |=> (cpu_pwr == CPU_SLEEP && !afe_on && !synth_on));
  // R5: processor fully active during computation
  p_compute_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_COMPUTE) |-> (cpu_pwr == CPU_ACTIVE && !adc_on && !filt_on));
endmodule

// File: tb/node_pwr_seq_test.sv
module node_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int SC = 20;
  localparam int WU = 3;

  // packed order {cpu_pwr[1:0], afe, adc, filt, rx, tx, synth}
  localparam logic [7:0] E_SLEEP    = 8'b00_000000;
  localparam logic [7:0] E_COLL_IDL = 8'b01_111000;
  localparam logic [7:0] E_COLL_ACT = 8'b10_111000;
  localparam logic [7:0] E_COMP     = 8'b10_000000;
  localparam logic [7:0] E_WARM     = 8'b10_000001;
  localparam logic [7:0] E_XMIT     = 8'b10_000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic compute_done = 1'b0;
  logic tx_done = 1'b0;
  logic wake_evt = 1'b0;
  logic [1:0] cpu_pwr;
  logic afe_on, adc_on, filt_on, rx_on, tx_on, synth_on;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  node_pwr_seq #(.NUM_SAMPLES(NS), .SLEEP_CYCLES(SC), .WARMUP_CYCLES(WU)) uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .compute_done(compute_done),
    .tx_done(tx_done), .wake_evt(wake_evt), .cpu_pwr(cpu_pwr), .afe_on(afe_on),
    .adc_on(adc_on), .filt_on(filt_on), .rx_on(rx_on), .tx_on(tx_on), .synth_on(synth_on)
  );

  function automatic logic [7:0] outs();
    return {cpu_pwr, afe_on, adc_on, filt_on, rx_on, tx_on, synth_on};
  endfunction

  task automatic chk(input string tag, input logic [7:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_cycle(input int wake_at, input int gap);
    if (wake_at < 0) begin
      int n = 0;
      while (!afe_on && n < SC + 5) begin
        step();
        n++;
      end
      checks++;
      if (n != SC) begin
        errors++;
        $display("FAIL R2 sleep length: got %0d expected %0d", n, SC);
      end
      chk("R2 collection after timer", E_COLL_IDL);
    end else begin
      sample_tick = 1'b1;
      repeat (wake_at) begin
        step();
        chk("R3 asleep before wake, R4 tick ignored in sleep", E_SLEEP);
      end
      wake_evt = 1'b1;
      step();
      wake_evt = 1'b0;
      sample_tick = 1'b0;
      chk("R3 wake event starts collection", E_COLL_IDL);
    end
    compute_done = 1'b1;
    tx_done = 1'b1;
    step();
    compute_done = 1'b0;
    tx_done = 1'b0;
    chk("R4 handshakes ignored in collection", E_COLL_IDL);
    for (int i = 0; i < NS; i++) begin
      sample_tick = 1'b1;
      step();
      sample_tick = 1'b0;
      if (i < NS - 1) begin
        chk("R4 processor active after tick", E_COLL_ACT);
        repeat (gap) begin
          step();
          chk("R4 processor idle between ticks", E_COLL_IDL);
        end
      end else begin
        chk("R5 compute after last sample", E_COMP);
      end
    end
    sample_tick = 1'b1;
    tx_done = 1'b1;
    repeat (4) begin
      step();
      chk("R6 compute held, tick and tx_done ignored", E_COMP);
    end
    sample_tick = 1'b0;
    tx_done = 1'b0;
    compute_done = 1'b1;
    step();
    compute_done = 1'b0;
    chk("R7 warm-up entered", E_WARM);
    for (int i = 1; i < WU; i++) begin
      step();
      chk("R7 warm-up continues", E_WARM);
    end
    step();
    chk("R7 transmit after warm-up", E_XMIT);
    checks++;
    if (rx_on !== 1'b0) begin
      errors++;
      $display("FAIL R9 receiver: got %b expected 0", rx_on);
    end
    compute_done = 1'b1;
    repeat (3) begin
      step();
      chk("R8 transmit held", E_XMIT);
    end
    compute_done = 1'b0;
    tx_done = 1'b1;
    step();
    tx_done = 1'b0;
    chk("R8 sleep after transmit", E_SLEEP);
  endtask

  initial begin
    wake_evt = 1'b1;
    sample_tick = 1'b1;
    repeat (3) step();
    chk("R1 reset state", E_SLEEP);
    wake_evt = 1'b0;
    sample_tick = 1'b0;
    rst_n = 1'b1;
    run_cycle(-1, 1);
    run_cycle(0, 0);
    run_cycle(5, 2);
    run_cycle(-1, 3);
    run_cycle(12, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule